// File: doc/BRIEF.md
# Indexed Block Serial Configuration Slave

This block is the slave side of a two-wire SMBus-style configuration port. A fast system clock oversamples the serial clock and data lines. The block recognises START, repeated START and STOP. It answers only its fixed 7-bit address and pulls the data line low, open-drain, for acknowledges and read data. On its back end it drives a small register file through a plain port: address, write data, write strobe and read data.

A block write is framed as address byte, starting offset, a byte count N, then N data bytes. A block read first sets the offset with a write-addressed frame. It then issues a repeated START with the read address. The slave answers with a count byte, then data from the offset upward, until the master declines a byte. An internal pointer advances after every data byte in both directions. Offsets past the last register are accepted but have no effect.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The slave acknowledges only the address bytes D2h (write) and D3h (read), which are the 7-bit address 1101001 followed by the direction bit. Any other address byte is not acknowledged, and the block ignores every following byte until the next START.
- R2: In a write frame the slave acknowledges the offset byte, the count byte N and N data bytes. It writes them to offset, offset+1 and so on, with exactly one write strobe per byte.
- R3: A count byte of 00h is not acknowledged, and the frame produces no register write.
- R4: Data bytes beyond the N announced by the count are not acknowledged and are not written.
- R5: After a repeated START and D3h, the slave sends the count byte 07h and then register data from the stored offset upward. Each byte is sent MSB first.
- R6: When the master does not acknowledge a read byte, the slave releases the data line. It drives nothing more until the next START.
- R7: Offsets 7 and above are acknowledged on write but cause no write strobe, and they read back as 00h.
- R8: An asynchronous low on the reset input releases the data line at once and returns the interface to idle with the pointer at 0.
- R9: A pulse of fewer than three system clocks on either bus line has no effect on the transfer.
- R10: A STOP ends any frame and releases the data line. Bytes clocked after it without a START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low power-down reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open-drain) |
| reg_addr | output | 3 | Register file address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register read data for reg_addr |

## Verification
Several properties are checked on every cycle by the assertions. The data line is never pulled low in idle. The slave begins driving only while the clock is low. Every write strobe is a single cycle and targets an existing register. A START always re-arms address reception. A zero count leaves the line released. A filtered line only changes after its samples agree. Framing behaviour can only be shown by the bench's bus transactions. This covers address matching, the count-limited write, read data order and the count byte, early master NACK, out-of-range offsets, glitch immunity and reset in mid-read. A scoreboard compares each write strobe with the writes the bench expects.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_OFFS,
    ST_WCNT,
    ST_WDAT,
    ST_RCNT,
    ST_RDAT
  } smb_st_e;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (&hist_q)       out_d = 1'b1;
    else if (~|hist_q) out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], din};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
      out_q  <= out_d;
    end
  end

  assign dout = out_q;

  // R9: the filtered level only moves after a full run of agreeing samples
  p_filter_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> ($past(&hist_q) || $past(~|hist_q)));
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_p  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_p   = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
endmodule

// File: rtl/smb_xfer_engine.sv
module smb_xfer_engine
  import smb_pkg::*;
#(
  parameter int          NUM_REGS = 7,
  parameter logic [6:0]  SLV_ADDR = 7'h69,
  parameter int          PTR_W    = 8,
  parameter int          AW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          scl_lvl,
  input  logic          sda_f,
  input  logic [7:0]    reg_rdata,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_we
);
  localparam logic [7:0]       WR_BYTE  = {SLV_ADDR, 1'b0};
  localparam logic [7:0]       RD_BYTE  = {SLV_ADDR, 1'b1};
  localparam logic [7:0]       CNT_BYTE = 8'(NUM_REGS);
  localparam logic [PTR_W-1:0] PTR_LIM  = PTR_W'(NUM_REGS);

  smb_st_e          st_q, st_d, aft_q, aft_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [7:0]       shr_q, shr_d, txd_q, txd_d, left_q, left_d, wdat_q, wdat_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic             oe_q, oe_d, we_q, we_d;
  logic             is_tx, in_range, ack_c, load_c;
  logic [7:0]       load_v, rd_byte;

  assign is_tx    = (st_q == ST_RCNT) || (st_q == ST_RDAT);
  assign in_range = ptr_q < PTR_LIM;
  assign rd_byte  = in_range ? reg_rdata : 8'h00;

  always_comb begin
    st_d   = st_q;
    aft_d  = aft_q;
    cnt_d  = cnt_q;
    shr_d  = shr_q;
    txd_d  = txd_q;
    ptr_d  = ptr_q;
    left_d = left_q;
    oe_d   = oe_q;
    we_d   = 1'b0;
    wdat_d = wdat_q;
    addr_d = ptr_q[AW-1:0];
    ack_c  = 1'b0;
    load_c = 1'b0;
    load_v = 8'h00;
    if (start_p) begin
      st_d  = ST_ADDR;
      cnt_d = 4'd0;
      oe_d  = 1'b0;
    end else if (stop_p) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (is_tx) begin
        if (scl_rise) begin
          if (cnt_q < 4'd8) cnt_d = cnt_q + 4'd1;
          else if (cnt_q == 4'd8) begin
            if (sda_f) begin
              st_d = ST_IDLE;
              oe_d = 1'b0;
            end else cnt_d = 4'd9;
          end
        end else if (scl_fall) begin
          if (cnt_q != 4'd0 && cnt_q < 4'd8) begin
            oe_d  = ~txd_q[7];
            txd_d = {txd_q[6:0], 1'b0};
          end else if (cnt_q == 4'd8) begin
            oe_d = 1'b0;
          end else if (cnt_q == 4'd9) begin
            st_d   = ST_RDAT;
            cnt_d  = 4'd0;
            load_c = 1'b1;
            load_v = rd_byte;
            ptr_d  = ptr_q + 1'b1;
          end
        end
      end else begin
        if (scl_rise && cnt_q < 4'd8) begin
          shr_d = {shr_q[6:0], sda_f};
          cnt_d = cnt_q + 4'd1;
        end else if (scl_fall && cnt_q == 4'd8) begin
          cnt_d = 4'd9;
          aft_d = ST_IDLE;
          case (st_q)
            ST_ADDR: begin
              if (shr_q == WR_BYTE) begin
                ack_c = 1'b1;
                aft_d = ST_OFFS;
              end else if (shr_q == RD_BYTE) begin
                ack_c = 1'b1;
                aft_d = ST_RCNT;
              end
            end
            ST_OFFS: begin
              ack_c = 1'b1;
              ptr_d = PTR_W'(shr_q);
              aft_d = ST_WCNT;
            end
            ST_WCNT: begin
              if (shr_q != 8'h00) begin
                ack_c  = 1'b1;
                left_d = shr_q;
                aft_d  = ST_WDAT;
              end
            end
            ST_WDAT: begin
              if (left_q != 8'h00) begin
                ack_c  = 1'b1;
                left_d = left_q - 8'd1;
                we_d   = in_range;
                wdat_d = shr_q;
                ptr_d  = ptr_q + 1'b1;
                aft_d  = ST_WDAT;
              end
            end
            default: aft_d = ST_IDLE;
          endcase
          oe_d = ack_c;
        end else if (scl_fall && cnt_q == 4'd9) begin
          st_d  = aft_q;
          cnt_d = 4'd0;
          oe_d  = 1'b0;
          if (aft_q == ST_RCNT) begin
            load_c = 1'b1;
            load_v = CNT_BYTE;
          end
        end
      end
    end
    if (load_c) begin
      oe_d  = ~load_v[7];
      txd_d = {load_v[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      aft_q  <= ST_IDLE;
      cnt_q  <= 4'd0;
      shr_q  <= 8'h00;
      txd_q  <= 8'h00;
      ptr_q  <= '0;
      left_q <= 8'h00;
      oe_q   <= 1'b0;
      we_q   <= 1'b0;
      wdat_q <= 8'h00;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      aft_q  <= aft_d;
      cnt_q  <= cnt_d;
      shr_q  <= shr_d;
      txd_q  <= txd_d;
      ptr_q  <= ptr_d;
      left_q <= left_d;
      oe_q   <= oe_d;
      we_q   <= we_d;
      wdat_q <= wdat_d;
      addr_q <= addr_d;
    end
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_wdata = wdat_q;
  assign reg_addr  = addr_q;

  // R6 / R10: nothing is driven while the interface is idle
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !oe_q);
  // R5: the slave only starts pulling the line while the clock is low
  p_drive_low_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_lvl);
  // R2: each accepted data byte gives a single-cycle strobe
  p_we_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);
  // R7: strobes never reach a non-existent register
  p_we_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (int'(addr_q) < NUM_REGS));
  // R1: a START always re-arms address reception
  p_start_rearm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (st_q == ST_ADDR && cnt_q == 4'd0));
  // R3: a zero count leaves the line released in its acknowledge slot
  p_zero_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WCNT && scl_fall && cnt_q == 4'd8 && shr_q == 8'h00
     && !start_p && !stop_p) |=> !oe_q);
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave #(
  parameter int         NUM_REGS = 7,
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter int         FILT_LEN = 3,
  parameter int         PTR_W    = 8,
  localparam int        AW       = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_we,
  input  logic [7:0]    reg_rdata
);
  logic [1:0] rs_q;
  logic       rst_s;
  logic [1:0] line_raw, line_flt;
  logic       start_p, stop_p, scl_rise, scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    smb_line_filter #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk  (clk),
      .rst_n(rst_s),
      .din  (line_raw[g]),
      .dout (line_flt[g])
    );
  end

  smb_bus_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_s),
    .scl_f   (line_flt[0]),
    .sda_f   (line_flt[1]),
    .start_p (start_p),
    .stop_p  (stop_p),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  smb_xfer_engine #(
    .NUM_REGS(NUM_REGS),
    .SLV_ADDR(SLV_ADDR),
    .PTR_W   (PTR_W),
    .AW      (AW)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_s),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .scl_lvl  (line_flt[0]),
    .sda_f    (line_flt[1]),
    .reg_rdata(reg_rdata),
    .sda_oe   (sda_oe),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_we   (reg_we)
  );
endmodule

// File: tb/cfg_smbus_slave_test.sv
module cfg_smbus_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe, reg_we, sda_line;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] regs [0:7];
  logic [7:0] exp_regs [0:6];
  logic [10:0] exp_q [$];
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = regs[reg_addr];

  cfg_smbus_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) if (reg_we) regs[reg_addr] <= reg_wdata;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe must match the next expected write (R2, R3, R4, R7)
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected write: actual %0h@%0d expected none", reg_wdata, reg_addr);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        if ({reg_addr, reg_wdata} !== e) begin
          fails++;
          $display("FAIL R2 write: actual %0h@%0d expected %0h@%0d",
                   reg_wdata, reg_addr, e[7:0], e[10:8]);
        end
      end
    end
  end

  task automatic push_wr(input int a, input logic [7:0] d);
    exp_q.push_back({3'(a), d});
    exp_regs[a] = d;
  endtask

  task automatic qd();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; qd();
    sda_m = 1'b0; qd();
    scl_m = 1'b0; qd();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; qd();
    scl_m = 1'b1; qd();
    sda_m = 1'b0; qd();
    scl_m = 1'b0; qd();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qd();
    scl_m = 1'b1; qd();
    sda_m = 1'b1; qd();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit gl, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qd();
      scl_m = 1'b1;
      if (gl && i == 7) begin
        repeat (4) @(negedge clk);
        sda_m = 1'b0;
        repeat (2) @(negedge clk);
        sda_m = 1'b1;
        repeat (Q - 6) @(negedge clk);
      end else qd();
      scl_m = 1'b0; qd();
    end
    sda_m = 1'b1; qd();
    scl_m = 1'b1; qd();
    ack = ~sda_line;
    scl_m = 1'b0; qd();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qd();
      scl_m = 1'b1; qd();
      b[i] = sda_line;
      scl_m = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; qd();
    scl_m = 1'b1; qd();
    scl_m = 1'b0; qd();
    sda_m = 1'b1;
  endtask

  task automatic glitch_scl();
    scl_m = 1'b1;
    repeat (2) @(negedge clk);
    scl_m = 1'b0; qd();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < 7; i++) begin
      regs[i] = 8'h50 + 8'(i);
      exp_regs[i] = 8'h50 + 8'(i);
    end
    regs[7] = 8'hAA;
    repeat (5) @(negedge clk);
    chk("R8 reset sda_oe", {7'd0, sda_oe}, 8'h00);
    chk("R8 reset reg_we", {7'd0, reg_we}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // block write of three bytes at offset 1
    bus_start();
    send_byte(8'hD2, 0, a); chk("R1 write address ack", {7'd0, a}, 8'h01);
    send_byte(8'h01, 0, a); chk("R2 offset ack", {7'd0, a}, 8'h01);
    send_byte(8'h03, 0, a); chk("R2 count ack", {7'd0, a}, 8'h01);
    push_wr(1, 8'h11); send_byte(8'h11, 0, a); chk("R2 data0 ack", {7'd0, a}, 8'h01);
    push_wr(2, 8'h22); send_byte(8'h22, 0, a); chk("R2 data1 ack", {7'd0, a}, 8'h01);
    push_wr(3, 8'h33); send_byte(8'h33, 0, a); chk("R2 data2 ack", {7'd0, a}, 8'h01);
    bus_stop();
    chk("R10 released after stop", {7'd0, sda_oe}, 8'h00);

    // block read from offset 0
    bus_start();
    send_byte(8'hD2, 0, a);
    send_byte(8'h00, 0, a);
    bus_rstart();
    send_byte(8'hD3, 0, a); chk("R1 read address ack", {7'd0, a}, 8'h01);
    recv_byte(1, d); chk("R5 count byte", d, 8'h07);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, d); chk("R5 read data", d, exp_regs[i]);
    end
    bus_stop();

    // zero count
    bus_start();
    send_byte(8'hD2, 0, a);
    send_byte(8'h04, 0, a);
    send_byte(8'h00, 0, a); chk("R3 zero count nack", {7'd0, a}, 8'h00);
    send_byte(8'h99, 0, a); chk("R3 byte after zero count nack", {7'd0, a}, 8'h00);
    bus_stop();

    // bytes beyond the count
    bus_start();
    send_byte(8'hD2, 0, a);
    send_byte(8'h05, 0, a);
    send_byte(8'h01, 0, a);
    push_wr(5, 8'h5E); send_byte(8'h5E, 0, a); chk("R2 single data ack", {7'd0, a}, 8'h01);
    send_byte(8'h6F, 0, a); chk("R4 extra byte nack", {7'd0, a}, 8'h00);
    bus_stop();

    // foreign address
    bus_start();
    send_byte(8'hA4, 0, a); chk("R1 foreign address nack", {7'd0, a}, 8'h00);
    send_byte(8'h00, 0, a); chk("R1 ignored until start", {7'd0, a}, 8'h00);
    bus_stop();

    // offsets past the last register
    bus_start();
    send_byte(8'hD2, 0, a);
    send_byte(8'h06, 0, a);
    send_byte(8'h02, 0, a);
    push_wr(6, 8'h77); send_byte(8'h77, 0, a); chk("R2 last register ack", {7'd0, a}, 8'h01);
    send_byte(8'h88, 0, a); chk("R7 out of range write ack", {7'd0, a}, 8'h01);
    bus_stop();
    bus_start();
    send_byte(8'hD2, 0, a);
    send_byte(8'h05, 0, a);
    bus_rstart();
    send_byte(8'hD3, 0, a);
    recv_byte(1, d); chk("R5 count byte again", d, 8'h07);
    recv_byte(1, d); chk("R5 data reg5", d, 8'h5E);
    recv_byte(1, d); chk("R5 data reg6", d, 8'h77);
    recv_byte(0, d); chk("R7 out of range read", d, 8'h00);
    bus_stop();

    // early master NACK
    bus_start();
    send_byte(8'hD2, 0, a);
    send_byte(8'h02, 0, a);
    bus_rstart();
    send_byte(8'hD3, 0, a);
    recv_byte(1, d);
    recv_byte(0, d); chk("R5 single byte read", d, 8'h22);
    recv_byte(0, d); chk("R6 released after nack", d, 8'hFF);
    bus_stop();

    // glitches on both lines
    bus_start();
    send_byte(8'hD2, 1, a); chk("R9 sda glitch ignored", {7'd0, a}, 8'h01);
    send_byte(8'h03, 0, a);
    glitch_scl();
    send_byte(8'h01, 0, a); chk("R9 scl glitch ignored", {7'd0, a}, 8'h01);
    push_wr(3, 8'h3C); send_byte(8'h3C, 0, a); chk("R9 data after glitch", {7'd0, a}, 8'h01);
    bus_stop();

    // bytes after STOP without START
    send_byte(8'hD2, 0, a); chk("R10 no start no ack", {7'd0, a}, 8'h00);
    bus_stop();

    // reset while the slave drives the line
    bus_start();
    send_byte(8'hD2, 0, a);
    send_byte(8'h00, 0, a);
    bus_rstart();
    send_byte(8'hD3, 0, a);
    chk("R5 count msb driven low", {7'd0, sda_oe}, 8'h01);
    rst_n = 1'b0;
    #1;
    chk("R8 async release", {7'd0, sda_oe}, 8'h00);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    bus_stop();
    bus_start();
    send_byte(8'hD3, 0, a); chk("R8 read after reset ack", {7'd0, a}, 8'h01);
    recv_byte(1, d);
    recv_byte(0, d); chk("R8 pointer back at 0", d, exp_regs[0]);
    bus_stop();

    repeat (20) @(negedge clk);
    chk("R2 all expected writes seen", 8'(exp_q.size()), 8'h00);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule